// File: doc/BRIEF.md
# ROM Rotate-and-Add Signature Engine

This block walks a read-only memory from word zero up to a programmed length and folds every word into a running signature. For each word the sum is first rotated left by one bit, and the word is then added. Because of the rotation, the result depends on the order of the words as well as on their values. A plain additive checksum does not have that property. The engine drives a synchronous ROM read port that has one cycle of latency. It issues one address per cycle, so it consumes one word per cycle once the pipeline has filled.

A one-cycle start pulse begins a run. The length, the compare enable and the expected value are captured with that pulse. At the end of the run the engine raises done and presents the final signature. When the compare is enabled, it also raises exactly one of pass or fail. A matching signature does not prove the ROM is fault-free, because this kind of checksum can miss some corruptions. Done stays high until the next accepted start. A start that arrives during a run is dropped.

Top module: `rom_sig_engine`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, fail_o and rom_re_o are all low.
- R2: An accepted start clears the signature to zero. It then reads addresses 0, 1, 2 and so on, one per cycle with rom_re_o high, for exactly len_i reads.
- R3: For each word, the new signature equals the old signature rotated left by one bit (bit DATA_W-1 moves to bit 0), plus the word, modulo 2^DATA_W. Carries out of the top bit are discarded.
- R4: The same set of words placed in a different order yields a different signature for words that differ under rotation. For example, 0x1234 followed by 0x0001 differs from 0x0001 followed by 0x1234.
- R5: For a non-zero length, done_o rises on the clock edge that comes len_i+1 edges after the edge that samples start. done_o and sig_o then hold until the next accepted start.
- R6: A start pulse that arrives while busy_o is high is ignored. The run continues with its original length, its original timing and its original signature.
- R7: With cmp_en_i high at start, pass_o is high when the final signature equals expect_i, and fail_o is high otherwise. With cmp_en_i low, both stay low. The two are never high together.
- R8: A length of zero gives done_o one edge after start, a signature of zero, and no ROM reads.
- R9: rom_re_o is only ever high while busy_o is high, and never with an address at or beyond the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, one cycle long |
| len_i | input | ADDR_W+1 | Number of words to read (0 to 2^ADDR_W) |
| cmp_en_i | input | 1 | Enables the pass/fail compare |
| expect_i | input | DATA_W | Expected signature |
| rom_addr_o | output | ADDR_W | ROM read address |
| rom_re_o | output | 1 | ROM read enable |
| rom_data_i | input | DATA_W | ROM data, valid one cycle after the read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete; held until the next start |
| sig_o | output | DATA_W | Signature |
| pass_o | output | 1 | Compare matched |
| fail_o | output | 1 | Compare mismatched |

## Verification
The checker assumes that the ROM returns valid data exactly one cycle after each enabled read. It also assumes that start_i is a single-cycle pulse and that len_i stays within 0 to 2^ADDR_W. The bench's ROM model registers its data on every enabled edge. The bench drives start high for exactly one cycle, on the falling clock, and keeps every length in range, including the full-depth case. Inputs other than start may change freely during a run, because the engine captures them only when a start is accepted.

// File: rtl/rse_pkg.sv
package rse_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} rse_state_e;

  function automatic logic [63:0] rotl_add(input logic [63:0] acc, input logic [63:0] word, input int w);
    logic [63:0] msk;
    logic [63:0] rot;
    msk = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    rot = ((acc << 1) | ((acc >> (w - 1)) & 64'd1)) & msk;
    return (rot + word) & msk;
  endfunction
endpackage

// File: rtl/rse_issue.sv
module rse_issue #(
  parameter int ADDR_W = 8,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              re_o
);
  logic [CNT_W-1:0] cnt_q;

  assign re_o   = run_i && (cnt_q < len_i);
  assign addr_o = cnt_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (re_o)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rse_accum.sv
module rse_accum
  import rse_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              re_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] acc_next_o,
  output logic              last_o
);
  logic             vld_q;
  logic [CNT_W-1:0] rcv_q;
  logic [63:0]      sum_wide;

  // rotate left by one, then add; the width cuts off the carry
  assign sum_wide   = rotl_add(64'(acc_o), 64'(data_i), DATA_W);
  assign acc_next_o = sum_wide[DATA_W-1:0];
  assign last_o     = vld_q && (rcv_q == len_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      rcv_q <= '0;
      acc_o <= '0;
    end else if (clear_i) begin
      vld_q <= 1'b0;
      rcv_q <= '0;
      acc_o <= '0;
    end else begin
      vld_q <= re_i;
      if (vld_q) begin
        acc_o <= acc_next_o;
        rcv_q <= rcv_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rse_verdict.sv
module rse_verdict #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              fin_i,
  input  logic              cmp_en_i,
  input  logic [DATA_W-1:0] expect_i,
  input  logic [DATA_W-1:0] final_i,
  output logic              pass_o,
  output logic              fail_o
);
  logic              cmp_q;
  logic [DATA_W-1:0] exp_q;
  logic              cmp_use;
  logic [DATA_W-1:0] exp_use;

  // a zero-length run finishes in the same cycle it starts
  assign cmp_use = accept_i ? cmp_en_i : cmp_q;
  assign exp_use = accept_i ? expect_i : exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= 1'b0;
      exp_q  <= '0;
      pass_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      if (accept_i) begin
        cmp_q <= cmp_en_i;
        exp_q <= expect_i;
      end
      if (fin_i) begin
        pass_o <= cmp_use && (final_i == exp_use);
        fail_o <= cmp_use && (final_i != exp_use);
      end else if (accept_i) begin
        pass_o <= 1'b0;
        fail_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rom_sig_engine.sv
module rom_sig_engine
  import rse_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              cmp_en_i,
  input  logic [DATA_W-1:0] expect_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rom_re_o,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] sig_o,
  output logic              pass_o,
  output logic              fail_o
);
  rse_state_e        state_q;
  logic [CNT_W-1:0]  len_q;
  logic              accept;
  logic              zero_len;
  logic              last;
  logic              fin;
  logic [DATA_W-1:0] acc_next;

  assign accept   = start_i && (state_q != ST_RUN);
  assign zero_len = (len_i == '0);
  assign fin      = last || (accept && zero_len);
  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
    end else begin
      if (accept) begin
        len_q   <= len_i;
        state_q <= zero_len ? ST_DONE : ST_RUN;
      end else if (busy_o && last) begin
        state_q <= ST_DONE;
      end
    end
  end

  rse_issue #(.ADDR_W(ADDR_W)) u_issue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .run_i   (busy_o),
    .len_i   (len_q),
    .addr_o  (rom_addr_o),
    .re_o    (rom_re_o)
  );

  rse_accum #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .re_i       (rom_re_o),
    .len_i      (len_q),
    .data_i     (rom_data_i),
    .acc_o      (sig_o),
    .acc_next_o (acc_next),
    .last_o     (last)
  );

  rse_verdict #(.DATA_W(DATA_W)) u_verdict (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .fin_i    (fin),
    .cmp_en_i (cmp_en_i),
    .expect_i (expect_i),
    .final_i  (accept ? '0 : acc_next),
    .pass_o   (pass_o),
    .fail_o   (fail_o)
  );
endmodule

// File: rtl/rom_sig_engine_chk.sv
module rom_sig_engine_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  localparam int CNT_W = ADDR_W + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CNT_W-1:0]  len_i,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic              rom_re_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] sig_o,
  input logic              pass_o,
  input logic              fail_o
);
  p_read_only_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_re_o |-> busy_o);

  p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_re_o && $past(rom_re_o)) |-> (rom_addr_o == $past(rom_addr_o) + 1'b1));

  p_done_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(sig_o)));

  p_verdict_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));

  p_verdict_when_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |-> done_o);

  p_busy_done_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  p_start_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && rom_re_o) |=> (busy_o && rom_addr_o == $past(rom_addr_o) + 1'b1));

  p_zero_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && len_i == '0) |=> (done_o && sig_o == '0 && !rom_re_o));
endmodule

bind rom_sig_engine rom_sig_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .len_i      (len_i),
  .rom_addr_o (rom_addr_o),
  .rom_re_o   (rom_re_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .sig_o      (sig_o),
  .pass_o     (pass_o),
  .fail_o     (fail_o)
);

// File: tb/rom_sig_engine_test.sv
module rom_sig_engine_test;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW:0]   len_i = '0;
  logic          cmp_en_i = 1'b0;
  logic [DW-1:0] expect_i = '0;
  logic [AW-1:0] rom_addr_o;
  logic          rom_re_o;
  logic [DW-1:0] rom_data_i;
  logic          busy_o, done_o, pass_o, fail_o;
  logic [DW-1:0] sig_o;

  logic [DW-1:0] mem [DEPTH];
  int total = 0;
  int bad = 0;
  int reads = 0;
  int oob = 0;
  int cur_len = 0;
  logic exp_addr_ok = 1'b1;
  int next_addr = 0;

  always #10 clk_i = ~clk_i;

  rom_sig_engine #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk_i, .rst_ni, .start_i, .len_i, .cmp_en_i, .expect_i,
    .rom_addr_o, .rom_re_o, .rom_data_i,
    .busy_o, .done_o, .sig_o, .pass_o, .fail_o
  );

  // synchronous ROM model, one cycle latency
  always @(posedge clk_i) begin
    if (rom_re_o) begin
      rom_data_i <= mem[rom_addr_o];
      reads++;
      if (int'(rom_addr_o) >= cur_len || !busy_o) oob++;
      if (int'(rom_addr_o) != next_addr) exp_addr_ok = 1'b0;
      next_addr++;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input int n);
    logic [DW-1:0] s = '0;
    for (int i = 0; i < n; i++) s = {s[DW-2:0], s[DW-1]} + mem[i];
    return s;
  endfunction

  // start on a falling edge; returns with start low one falling edge later
  task automatic pulse_start(input int n, input logic cmp, input logic [DW-1:0] ex);
    len_i = n[AW:0]; cmp_en_i = cmp; expect_i = ex;
    cur_len = n; reads = 0; next_addr = 0; exp_addr_ok = 1'b1; oob = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic run_and_check(input string tag, input int n, input logic cmp, input logic [DW-1:0] ex);
    logic [DW-1:0] want = model(n);
    pulse_start(n, cmp, ex);
    // now at falling edge N1; done appears at N(n+2)
    for (int k = 1; k < n + 1; k++) @(negedge clk_i);
    if (n > 0) begin
      check({tag, " R5 done not early"}, done_o, 1'b0);
      @(negedge clk_i);
    end
    check({tag, " R5 done on time"}, done_o, 1'b1);
    check({tag, " R3 signature"}, sig_o, want);
    check({tag, " R2 read count"}, reads, n);
    check({tag, " R2 address order"}, exp_addr_ok, 1'b1);
    check({tag, " R9 no out-of-range read"}, oob, 0);
    check({tag, " R7 pass"}, pass_o, cmp && (want == ex));
    check({tag, " R7 fail"}, fail_o, cmp && (want != ex));
    repeat (3) @(negedge clk_i);
    check({tag, " R5 done held"}, done_o, 1'b1);
    check({tag, " R5 sig held"}, sig_o, want);
  endtask

  task automatic t_reset;
    check("R1 busy", busy_o, 0);
    check("R1 done", done_o, 0);
    check("R1 pass", pass_o, 0);
    check("R1 fail", fail_o, 0);
    check("R1 re", rom_re_o, 0);
  endtask

  task automatic t_basic;
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * 37 + 5);
    run_and_check("basic", 10, 1'b0, '0);
    run_and_check("match", 12, 1'b1, model(12));
    run_and_check("mismatch", 12, 1'b1, model(12) ^ 16'h0100);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'hFFFF;
    run_and_check("ovf R3", 5, 1'b0, '0);
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * 4099 + 17);
    run_and_check("full", DEPTH, 1'b1, model(DEPTH));
  endtask

  task automatic t_order;
    logic [DW-1:0] s_a, s_b;
    mem[0] = 16'h1234; mem[1] = 16'h0001;
    run_and_check("order A", 2, 1'b0, '0);
    s_a = sig_o;
    mem[0] = 16'h0001; mem[1] = 16'h1234;
    run_and_check("order B", 2, 1'b0, '0);
    s_b = sig_o;
    check("R4 order sensitive", (s_a != s_b), 1'b1);
    check("R4 value A", s_a, 16'h2469);
    check("R4 value B", s_b, 16'h1236);
  endtask

  task automatic t_zero;
    pulse_start(0, 1'b1, '0);
    check("R8 done", done_o, 1);
    check("R8 sig zero", sig_o, 0);
    check("R8 pass", pass_o, 1);
    @(negedge clk_i);
    check("R8 no reads", reads, 0);
  endtask

  task automatic t_busy_start;
    logic [DW-1:0] want;
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * 91 + 3);
    want = model(8);
    pulse_start(8, 1'b0, '0);
    @(negedge clk_i);
    @(negedge clk_i);
    // second start while busy, different length
    len_i = 9'd3; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R6 still busy", busy_o, 1);
    for (int k = 4; k < 9; k++) @(negedge clk_i);
    check("R6 done not early", done_o, 0);
    @(negedge clk_i);
    check("R6 done on original time", done_o, 1);
    check("R6 original signature", sig_o, want);
    check("R6 original read count", reads, 8);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_basic();
        t_overflow();
        t_order();
        t_zero();
        t_busy_start();
      end
      begin
        repeat (20000) @(negedge clk_i);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule